// File: doc/BRIEF.md
# Packet Fragment Descriptor Generator

The block turns a packet into a stream of 128-bit send-DMA descriptors. A packet begins with a start command. The command carries the total length in bytes, an urgent flag, a header-generation mode and a header-store index. After the command, the fragments follow on a valid/ready stream. Each fragment is a 48-bit address, a 14-bit byte count and a 2-bit mapping-type tag. Every accepted fragment becomes one descriptor in a registered output slot, which the downstream engine drains through its own valid/ready handshake.

A down-counter is loaded with the packet length, and each fragment's byte count is subtracted from it. The fragment that brings the counter to zero ends the data. If the packet length is not a multiple of four, one more descriptor of 1 to 3 bytes follows. It points at a pad buffer whose base address is a block input, and the end marker goes on this pad descriptor rather than on the last data fragment.

The header-generation fields are merged only into the first descriptor. The urgent completion bits are placed only on the final descriptor. The block rejects a bad command, and it aborts a packet whose fragments overrun the declared length or that would need more descriptors than the per-packet limit.

Top module: `pkt_desc_gen`

## Requirements
- R1: After reset, `desc_valid`, `frag_ready`, `cmd_reject` and `err_abort` are 0 and `start_ready` is 1.
- R2: Word 0 of a descriptor holds the first marker in bit 63, the end marker in bit 62, the byte count in bits 61:48 and the address in bits 47:0. Word 1 holds the mapping type in bits 3:2.
- R3: Only the first descriptor of a packet has bit 63 of word 0 set. Only that descriptor carries the header mode in word 1 bits 15:13 and the header index in bits 12:8; every other descriptor has word 1 bits 15:8 equal to zero.
- R4: A start command with length 0, with a length above 16383, or with a header mode above 4 is refused. `cmd_reject` pulses in the cycle after the command, no descriptor is produced and the block stays ready for a new command.
- R5: Each accepted fragment lowers the remaining length by its byte count. When the remaining length reaches zero and the packet length is a multiple of 4, that fragment's descriptor carries the end marker.
- R6: When the packet length modulo 4 is nonzero, one pad descriptor follows the final data fragment. Its byte count is 4 minus that remainder, its address is `pad_base` and its mapping type is 0. The end marker is set on the pad descriptor and clear on the data descriptor before it.
- R7: With the urgent flag set, the final descriptor has word 1 bits 1 (interrupt request) and 0 (head write-back) set. All other descriptors have both bits clear.
- R8: A fragment longer than the remaining length is consumed without producing a descriptor. `err_abort` pulses in the next cycle, no end descriptor is emitted and the block returns to waiting for a command.
- R9: A packet uses at most 64 descriptors, the pad included. A fragment that would be the 65th descriptor aborts as in R8. So does a final data fragment that is the 64th descriptor when a pad is still required.
- R10: While `desc_valid` is 1 and `desc_ready` is 0, the descriptor words hold steady and `frag_ready` is 0.
- R11: A packet of one fragment whose length is a multiple of 4 produces a single descriptor with both the first and the end markers set.
- R12: Header modes 0 to 4 (0 none, 1 copy into store, 2/3/4 apply one/two/three update words) are all accepted and passed unchanged into the first descriptor.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_valid | input | 1 | Start command present |
| start_ready | output | 1 | Block is idle and takes a command |
| start_len | input | 16 | Total packet length in bytes |
| start_urgent | input | 1 | Request completion bits on the final descriptor |
| start_hdr_mode | input | 3 | Header-generation mode for the first descriptor |
| start_hdr_idx | input | 5 | Header-store index for the first descriptor |
| cmd_reject | output | 1 | One-cycle pulse: the last command was refused |
| pad_base | input | 48 | Address of the pad buffer |
| frag_valid | input | 1 | Fragment present |
| frag_ready | output | 1 | Fragment accepted on this edge when valid |
| frag_addr | input | 48 | Fragment address |
| frag_len | input | 14 | Fragment byte count |
| frag_type | input | 2 | Fragment mapping-type tag |
| desc_valid | output | 1 | Descriptor slot occupied |
| desc_ready | input | 1 | Downstream takes the descriptor |
| desc_w0 | output | 64 | Descriptor word 0 |
| desc_w1 | output | 64 | Descriptor word 1 |
| err_abort | output | 1 | One-cycle pulse: the current packet was aborted |

## Verification
The fragment splits cover a single fragment, several fragments of unequal size, and packet lengths with each of the four remainders modulo 4. Together they show whether the end marker lands on the data or on the pad descriptor, and whether the header and urgent fields are confined to their own descriptor. The length patterns include 0, 16383, 16384 and a fragment that overshoots the remaining count, which separates refused commands from mid-packet aborts. Packets of 64 one-byte fragments, 65 one-byte fragments and a 66-byte packet ending with its 64th fragment probe the descriptor limit, with and without a pending pad. A held-off consumer shows that the output slot is frozen and fragment intake stops.

// File: rtl/pdg_pkg.sv
`timescale 1ns/1ps
package pdg_pkg;

    localparam int ADDR_W   = 48;
    localparam int BCNT_W   = 14;
    localparam int HMODE_W  = 3;
    localparam int HIDX_W   = 5;
    localparam int MTYPE_W  = 2;
    localparam int WORD_W   = 64;

    // word 0 field positions
    localparam int W0_FIRST    = 63;
    localparam int W0_LAST     = 62;
    localparam int W0_BCNT_LSB = 48;
    localparam int W0_ADDR_LSB = 0;
    // word 1 field positions
    localparam int W1_HMODE_LSB = 13;
    localparam int W1_HIDX_LSB  = 8;
    localparam int W1_MTYPE_LSB = 2;
    localparam int W1_INTR      = 1;
    localparam int W1_HWB       = 0;

    typedef enum logic [HMODE_W-1:0] {
        HM_NONE = 3'd0,
        HM_COPY = 3'd1,
        HM_UPD1 = 3'd2,
        HM_UPD2 = 3'd3,
        HM_UPD3 = 3'd4
    } hdr_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DATA = 2'd1,
        ST_PAD  = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic               urgent;
        logic [HMODE_W-1:0] hmode;
        logic [HIDX_W-1:0]  hidx;
    } pkt_ctx_t;

    typedef struct packed {
        logic               first;
        logic               last;
        logic [BCNT_W-1:0]  bcnt;
        logic [ADDR_W-1:0]  addr;
        logic [HMODE_W-1:0] hmode;
        logic [HIDX_W-1:0]  hidx;
        logic [MTYPE_W-1:0] mtype;
        logic               intr;
        logic               hwb;
    } desc_fields_t;

    typedef struct packed {
        logic [WORD_W-1:0] w1;
        logic [WORD_W-1:0] w0;
    } desc_raw_t;

    function automatic desc_raw_t pack_desc(input desc_fields_t f);
        desc_raw_t r;
        r = '0;
        r.w0[W0_FIRST]                   = f.first;
        r.w0[W0_LAST]                    = f.last;
        r.w0[W0_BCNT_LSB +: BCNT_W]      = f.bcnt;
        r.w0[W0_ADDR_LSB +: ADDR_W]      = f.addr;
        r.w1[W1_HMODE_LSB +: HMODE_W]    = f.hmode;
        r.w1[W1_HIDX_LSB +: HIDX_W]      = f.hidx;
        r.w1[W1_MTYPE_LSB +: MTYPE_W]    = f.mtype;
        r.w1[W1_INTR]                    = f.intr;
        r.w1[W1_HWB]                     = f.hwb;
        return r;
    endfunction

    // bytes needed to round a length up to a dword boundary
    function automatic logic [1:0] pad_for(input logic [1:0] low);
        return 2'(3'd4 - {1'b0, low});
    endfunction

endpackage

// File: rtl/pdg_cmd_check.sv
`timescale 1ns/1ps
module pdg_cmd_check
    import pdg_pkg::*;
#(
    parameter int LEN_W   = 16,
    parameter int MAX_LEN = 16383
) (
    input  logic [LEN_W-1:0]   len,
    input  logic [HMODE_W-1:0] hmode,
    output logic               ok
);
    localparam logic [LEN_W-1:0] LEN_LIMIT = LEN_W'(MAX_LEN);

    logic len_nonzero;
    logic len_in_range;
    logic mode_known;

    assign len_nonzero  = (len != '0);
    assign len_in_range = (len <= LEN_LIMIT);
    assign mode_known   = (hmode <= HMODE_W'(HM_UPD3));
    assign ok           = len_nonzero && len_in_range && mode_known;
endmodule

// File: rtl/pdg_seq.sv
`timescale 1ns/1ps
module pdg_seq
    import pdg_pkg::*;
#(
    parameter int LEN_W    = 16,
    parameter int MAX_DESC = 64
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start_valid,
    input  logic               start_ok,
    input  logic [LEN_W-1:0]   start_len,
    input  pkt_ctx_t           start_ctx,
    output logic               start_ready,
    output logic               cmd_reject,
    input  logic               frag_valid,
    output logic               frag_ready,
    input  logic [ADDR_W-1:0]  frag_addr,
    input  logic [BCNT_W-1:0]  frag_len,
    input  logic [MTYPE_W-1:0] frag_type,
    input  logic [ADDR_W-1:0]  pad_base,
    input  logic               out_free,
    output logic               emit,
    output desc_fields_t       emit_f,
    output logic               err_abort
);
    localparam int CNT_W = $clog2(MAX_DESC + 1);
    localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(MAX_DESC);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(MAX_DESC - 1);

    seq_state_e       state;
    logic [LEN_W-1:0] rem;
    logic [1:0]       pad_len;
    pkt_ctx_t         ctx;
    logic             first_pend;
    logic [CNT_W-1:0] dcnt;

    logic [LEN_W-1:0] flen_ext;
    logic [LEN_W-1:0] rem_next;
    logic             frag_fire;
    logic             overrun;
    logic             data_done;
    logic             need_pad;
    logic             cap_full;
    logic             no_pad_room;
    logic             abort;
    logic             pad_fire;
    logic             data_last;

    assign start_ready = (state == ST_IDLE);
    assign frag_ready  = (state == ST_DATA) && out_free;
    assign frag_fire   = frag_valid && frag_ready;

    assign flen_ext    = LEN_W'(frag_len);
    assign overrun     = flen_ext > rem;
    assign rem_next    = rem - flen_ext;
    assign data_done   = (rem_next == '0);
    assign need_pad    = (pad_len != 2'd0);
    assign cap_full    = (dcnt == CNT_MAX);
    assign no_pad_room = data_done && need_pad && (dcnt == CNT_LAST);
    assign abort       = frag_fire && (overrun || cap_full || no_pad_room);
    assign pad_fire    = (state == ST_PAD) && out_free;
    assign data_last   = data_done && !need_pad;
    assign emit        = (frag_fire && !abort) || pad_fire;

    always_comb begin
        emit_f = '0;
        if (state == ST_PAD) begin
            emit_f.last  = 1'b1;
            emit_f.bcnt  = BCNT_W'(pad_len);
            emit_f.addr  = pad_base;
            emit_f.intr  = ctx.urgent;
            emit_f.hwb   = ctx.urgent;
        end else begin
            emit_f.first = first_pend;
            emit_f.last  = data_last;
            emit_f.bcnt  = frag_len;
            emit_f.addr  = frag_addr;
            emit_f.mtype = frag_type;
            emit_f.intr  = data_last && ctx.urgent;
            emit_f.hwb   = data_last && ctx.urgent;
            if (first_pend) begin
                emit_f.hmode = ctx.hmode;
                emit_f.hidx  = ctx.hidx;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            rem        <= '0;
            pad_len    <= 2'd0;
            ctx        <= '0;
            first_pend <= 1'b0;
            dcnt       <= '0;
            cmd_reject <= 1'b0;
            err_abort  <= 1'b0;
        end else begin
            cmd_reject <= start_valid && start_ready && !start_ok;
            err_abort  <= abort;
            unique case (state)
                ST_IDLE: begin
                    if (start_valid && start_ok) begin
                        rem        <= start_len;
                        pad_len    <= pad_for(start_len[1:0]);
                        ctx        <= start_ctx;
                        first_pend <= 1'b1;
                        dcnt       <= '0;
                        state      <= ST_DATA;
                    end
                end
                ST_DATA: begin
                    if (abort) begin
                        state <= ST_IDLE;
                    end else if (frag_fire) begin
                        rem        <= rem_next;
                        first_pend <= 1'b0;
                        dcnt       <= dcnt + CNT_W'(1);
                        if (data_done) begin
                            state <= need_pad ? ST_PAD : ST_IDLE;
                        end
                    end
                end
                ST_PAD: begin
                    if (out_free) begin
                        dcnt  <= dcnt + CNT_W'(1);
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R5
    rem_mono_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DATA && $past(state) == ST_DATA) |-> (rem <= $past(rem)));

    // R9
    desc_cap_chk: assert property (@(posedge clk) disable iff (rst)
        dcnt <= CNT_MAX);

    // R4
    reject_src_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_reject |-> $past(start_valid));

    // R8
    abort_src_chk: assert property (@(posedge clk) disable iff (rst)
        err_abort |-> ($past(frag_valid) && state == ST_IDLE));

    // R6
    pad_len_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PAD) |-> (pad_len != 2'd0));
endmodule

// File: rtl/pdg_out_stage.sv
`timescale 1ns/1ps
module pdg_out_stage
    import pdg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              emit,
    input  desc_fields_t      emit_f,
    output logic              out_free,
    output logic              desc_valid,
    input  logic              desc_ready,
    output logic [WORD_W-1:0] desc_w0,
    output logic [WORD_W-1:0] desc_w1
);
    desc_raw_t slot;

    assign out_free = !desc_valid || desc_ready;
    assign desc_w0  = slot.w0;
    assign desc_w1  = slot.w1;

    always_ff @(posedge clk) begin
        if (rst) begin
            desc_valid <= 1'b0;
            slot       <= '0;
        end else if (out_free) begin
            desc_valid <= emit;
            if (emit) begin
                slot <= pack_desc(emit_f);
            end
        end
    end

    // R10
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (desc_valid && !desc_ready) |=>
            (desc_valid && $stable(desc_w0) && $stable(desc_w1)));

    // R10
    no_drop_chk: assert property (@(posedge clk) disable iff (rst)
        emit |-> out_free);

    // R3
    hdr_first_only_chk: assert property (@(posedge clk) disable iff (rst)
        (desc_valid && !desc_w0[W0_FIRST]) |->
            (desc_w1[W1_HIDX_LSB +: (HMODE_W + HIDX_W)] == '0));
endmodule

// File: rtl/pkt_desc_gen.sv
`timescale 1ns/1ps
module pkt_desc_gen
    import pdg_pkg::*;
#(
    parameter int LEN_W    = 16,
    parameter int MAX_LEN  = 16383,
    parameter int MAX_DESC = 64
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start_valid,
    output logic               start_ready,
    input  logic [LEN_W-1:0]   start_len,
    input  logic               start_urgent,
    input  logic [HMODE_W-1:0] start_hdr_mode,
    input  logic [HIDX_W-1:0]  start_hdr_idx,
    output logic               cmd_reject,
    input  logic [ADDR_W-1:0]  pad_base,
    input  logic               frag_valid,
    output logic               frag_ready,
    input  logic [ADDR_W-1:0]  frag_addr,
    input  logic [BCNT_W-1:0]  frag_len,
    input  logic [MTYPE_W-1:0] frag_type,
    output logic               desc_valid,
    input  logic               desc_ready,
    output logic [WORD_W-1:0]  desc_w0,
    output logic [WORD_W-1:0]  desc_w1,
    output logic               err_abort
);
    logic         start_ok;
    pkt_ctx_t     start_ctx;
    logic         out_free;
    logic         emit;
    desc_fields_t emit_f;

    assign start_ctx = '{urgent: start_urgent, hmode: start_hdr_mode, hidx: start_hdr_idx};

    pdg_cmd_check #(
        .LEN_W   (LEN_W),
        .MAX_LEN (MAX_LEN)
    ) u_check (
        .len   (start_len),
        .hmode (start_hdr_mode),
        .ok    (start_ok)
    );

    pdg_seq #(
        .LEN_W    (LEN_W),
        .MAX_DESC (MAX_DESC)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .start_valid (start_valid),
        .start_ok    (start_ok),
        .start_len   (start_len),
        .start_ctx   (start_ctx),
        .start_ready (start_ready),
        .cmd_reject  (cmd_reject),
        .frag_valid  (frag_valid),
        .frag_ready  (frag_ready),
        .frag_addr   (frag_addr),
        .frag_len    (frag_len),
        .frag_type   (frag_type),
        .pad_base    (pad_base),
        .out_free    (out_free),
        .emit        (emit),
        .emit_f      (emit_f),
        .err_abort   (err_abort)
    );

    pdg_out_stage u_out (
        .clk        (clk),
        .rst        (rst),
        .emit       (emit),
        .emit_f     (emit_f),
        .out_free   (out_free),
        .desc_valid (desc_valid),
        .desc_ready (desc_ready),
        .desc_w0    (desc_w0),
        .desc_w1    (desc_w1)
    );
endmodule

// File: tb/pkt_desc_gen_bench.sv
`timescale 1ns/1ps
module pkt_desc_gen_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_valid = 1'b0;
    logic        start_ready;
    logic [15:0] start_len = '0;
    logic        start_urgent = 1'b0;
    logic [2:0]  start_hdr_mode = '0;
    logic [4:0]  start_hdr_idx = '0;
    logic        cmd_reject;
    logic [47:0] pad_base = 48'h0000_BEEF_0000;
    logic        frag_valid = 1'b0;
    logic        frag_ready;
    logic [47:0] frag_addr = '0;
    logic [13:0] frag_len = '0;
    logic [1:0]  frag_type = '0;
    logic        desc_valid;
    logic        desc_ready = 1'b1;
    logic [63:0] desc_w0;
    logic [63:0] desc_w1;
    logic        err_abort;

    pkt_desc_gen u_pkt_desc_gen (
        .clk(clk), .rst(rst),
        .start_valid(start_valid), .start_ready(start_ready), .start_len(start_len),
        .start_urgent(start_urgent), .start_hdr_mode(start_hdr_mode),
        .start_hdr_idx(start_hdr_idx), .cmd_reject(cmd_reject), .pad_base(pad_base),
        .frag_valid(frag_valid), .frag_ready(frag_ready), .frag_addr(frag_addr),
        .frag_len(frag_len), .frag_type(frag_type), .desc_valid(desc_valid),
        .desc_ready(desc_ready), .desc_w0(desc_w0), .desc_w1(desc_w1),
        .err_abort(err_abort)
    );

    always #2.5 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    int rej_cnt = 0;
    int err_cnt = 0;
    logic [127:0] capq[$];
    logic [127:0] expq[$];

    always @(negedge clk) begin
        if (!rst) begin
            if (desc_valid && desc_ready) capq.push_back({desc_w1, desc_w0});
            if (cmd_reject) rej_cnt++;
            if (err_abort) err_cnt++;
        end
    end

    function automatic logic [127:0] mk(bit f, bit l, int unsigned bc, logic [47:0] a,
                                        int unsigned ty, int unsigned hm, int unsigned hi, bit urg);
        logic [63:0] w0;
        logic [63:0] w1;
        w0 = (64'(f) << 63) | (64'(l) << 62) | ((64'(bc) & 64'h3FFF) << 48) | 64'(a);
        w1 = (64'(hm) << 13) | (64'(hi) << 8) | (64'(ty) << 2) | (urg ? 64'h3 : 64'h0);
        return {w1, w0};
    endfunction

    task automatic chk_v(string req, logic [127:0] act, logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk_i(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_queue(string req);
        chk_i({req, " count"}, capq.size(), expq.size());
        for (int i = 0; i < expq.size() && i < capq.size(); i++) begin
            chk_v(req, capq[i], expq[i]);
        end
    endtask

    task automatic begin_case();
        capq.delete();
        expq.delete();
        rej_cnt = 0;
        err_cnt = 0;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic send_cmd(int unsigned len, bit urg, int unsigned hm, int unsigned hi);
        @(negedge clk);
        start_valid    = 1'b1;
        start_len      = 16'(len);
        start_urgent   = urg;
        start_hdr_mode = 3'(hm);
        start_hdr_idx  = 5'(hi);
        #1;
        while (!start_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        #1;
        start_valid = 1'b0;
    endtask

    task automatic push_frag(logic [47:0] a, int unsigned len, int unsigned ty);
        @(negedge clk);
        frag_valid = 1'b1;
        frag_addr  = a;
        frag_len   = 14'(len);
        frag_type  = 2'(ty);
        #1;
        while (!frag_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        #1;
        frag_valid = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk_v("R1 reset outputs", 128'({desc_valid, start_ready, frag_ready, err_abort, cmd_reject}),
              128'(5'b01000));
    endtask

    task automatic t_single();
        begin_case();
        send_cmd(8, 0, 0, 0);
        push_frag(48'h1234_5678_9ABC, 8, 2);
        settle();
        expq.push_back(mk(1, 1, 8, 48'h1234_5678_9ABC, 2, 0, 0, 0));
        chk_queue("R11 R2 single fragment");
        chk_i("R11 back to idle", int'(start_ready), 1);
    endtask

    task automatic t_multi();
        begin_case();
        send_cmd(20, 1, 1, 5);
        push_frag(48'h0000_0000_1000, 8, 1);
        push_frag(48'h0000_0000_2000, 4, 2);
        push_frag(48'h0000_0000_3000, 8, 3);
        settle();
        expq.push_back(mk(1, 0, 8, 48'h1000, 1, 1, 5, 0));
        expq.push_back(mk(0, 0, 4, 48'h2000, 2, 0, 0, 0));
        expq.push_back(mk(0, 1, 8, 48'h3000, 3, 0, 0, 1));
        chk_queue("R3 R5 R7 multi fragment");
    endtask

    task automatic t_pad();
        begin_case();
        send_cmd(10, 1, 0, 0);
        push_frag(48'hA000, 6, 1);
        push_frag(48'hB000, 4, 2);
        settle();
        expq.push_back(mk(1, 0, 6, 48'hA000, 1, 0, 0, 0));
        expq.push_back(mk(0, 0, 4, 48'hB000, 2, 0, 0, 0));
        expq.push_back(mk(0, 1, 2, pad_base, 0, 0, 0, 1));
        chk_queue("R6 R7 pad of 2 urgent");

        begin_case();
        send_cmd(5, 0, 0, 0);
        push_frag(48'hC000, 5, 3);
        settle();
        expq.push_back(mk(1, 0, 5, 48'hC000, 3, 0, 0, 0));
        expq.push_back(mk(0, 1, 3, pad_base, 0, 0, 0, 0));
        chk_queue("R6 pad of 3");

        begin_case();
        send_cmd(7, 0, 0, 0);
        push_frag(48'hD000, 7, 1);
        settle();
        expq.push_back(mk(1, 0, 7, 48'hD000, 1, 0, 0, 0));
        expq.push_back(mk(0, 1, 1, pad_base, 0, 0, 0, 0));
        chk_queue("R6 pad of 1");
    endtask

    task automatic t_reject();
        begin_case();
        send_cmd(0, 0, 0, 0);
        send_cmd(16384, 0, 0, 0);
        send_cmd(20, 0, 5, 0);
        settle();
        chk_i("R4 reject pulses", rej_cnt, 3);
        chk_queue("R4 no output on reject");
        chk_i("R4 still idle", int'({start_ready, frag_ready}), 2);

        begin_case();
        send_cmd(16383, 0, 2, 9);
        push_frag(48'hE000, 16383, 1);
        settle();
        chk_i("R4 max length accepted", rej_cnt, 0);
        expq.push_back(mk(1, 0, 16383, 48'hE000, 1, 2, 9, 0));
        expq.push_back(mk(0, 1, 1, pad_base, 0, 0, 0, 0));
        chk_queue("R4 R6 max length packet");
    endtask

    task automatic t_overrun();
        begin_case();
        send_cmd(8, 1, 0, 0);
        push_frag(48'hF000, 4, 1);
        push_frag(48'hF100, 6, 1);
        settle();
        chk_i("R8 abort pulse", err_cnt, 1);
        expq.push_back(mk(1, 0, 4, 48'hF000, 1, 0, 0, 0));
        chk_queue("R8 no end descriptor");
        chk_i("R8 idle after abort", int'(start_ready), 1);

        begin_case();
        send_cmd(4, 0, 0, 0);
        push_frag(48'hF200, 4, 0);
        settle();
        expq.push_back(mk(1, 1, 4, 48'hF200, 0, 0, 0, 0));
        chk_queue("R8 recovery packet");
    endtask

    task automatic t_stall();
        bit done;
        logic [63:0] held;
        begin_case();
        done = 1'b0;
        desc_ready = 1'b0;
        send_cmd(12, 0, 0, 0);
        fork
            begin
                push_frag(48'h100, 4, 1);
                push_frag(48'h200, 4, 2);
                push_frag(48'h300, 4, 3);
                done = 1'b1;
            end
        join_none
        repeat (6) @(negedge clk);
        chk_i("R10 slot occupied", int'(desc_valid), 1);
        chk_i("R10 intake stopped", int'(frag_ready), 0);
        held = desc_w0;
        repeat (3) @(negedge clk);
        chk_v("R10 words held", 128'(desc_w0), 128'(held));
        desc_ready = 1'b1;
        while (!done) @(negedge clk);
        settle();
        expq.push_back(mk(1, 0, 4, 48'h100, 1, 0, 0, 0));
        expq.push_back(mk(0, 0, 4, 48'h200, 2, 0, 0, 0));
        expq.push_back(mk(0, 1, 4, 48'h300, 3, 0, 0, 0));
        chk_queue("R10 order after stall");
    endtask

    task automatic t_limit();
        begin_case();
        send_cmd(64, 0, 0, 0);
        for (int i = 0; i < 64; i++) push_frag(48'(i), 1, 0);
        settle();
        chk_i("R9 64 descriptors allowed", capq.size(), 64);
        chk_i("R9 no abort at 64", err_cnt, 0);
        if (capq.size() == 64) chk_v("R9 64th is end", capq[63], mk(0, 1, 1, 48'd63, 0, 0, 0, 0));

        begin_case();
        send_cmd(65, 0, 0, 0);
        for (int i = 0; i < 65; i++) push_frag(48'(i), 1, 0);
        settle();
        chk_i("R9 65th fragment aborts", err_cnt, 1);
        chk_i("R9 descriptors before abort", capq.size(), 64);
        if (capq.size() == 64) chk_i("R9 no end flag", int'(capq[63][62]), 0);

        begin_case();
        send_cmd(66, 0, 0, 0);
        for (int i = 0; i < 63; i++) push_frag(48'(i), 1, 0);
        push_frag(48'h40, 3, 0);
        settle();
        chk_i("R9 no room for pad aborts", err_cnt, 1);
        chk_i("R9 descriptors before pad abort", capq.size(), 63);
    endtask

    task automatic t_modes();
        begin_case();
        send_cmd(4, 0, 4, 31);
        push_frag(48'h5000, 4, 1);
        send_cmd(8, 0, 2, 3);
        push_frag(48'h6000, 4, 0);
        push_frag(48'h6100, 4, 0);
        send_cmd(4, 0, 3, 17);
        push_frag(48'h7000, 4, 2);
        settle();
        expq.push_back(mk(1, 1, 4, 48'h5000, 1, 4, 31, 0));
        expq.push_back(mk(1, 0, 4, 48'h6000, 0, 2, 3, 0));
        expq.push_back(mk(0, 1, 4, 48'h6100, 0, 0, 0, 0));
        expq.push_back(mk(1, 1, 4, 48'h7000, 2, 3, 17, 0));
        chk_queue("R12 R3 header modes");
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #500000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_single();
        t_multi();
        t_pad();
        t_reject();
        t_overrun();
        t_stall();
        t_limit();
        t_modes();
        report();
    end

endmodule